// File: doc/BRIEF.md
# Real-Time Clock with Coherent Bus-Side Time Registers

This block keeps wall-clock time for a chip. A one-cycle strobe marks each period of a 32.768 kHz reference. The block keeps a 32-bit seconds count and a milliseconds count in the range 0 to 999. The milliseconds count advances through a fractional accumulator, so that exactly 1000 milliseconds elapse per second of reference periods. The live counts are not read directly by software. Once every eight reference periods the block raises a busy flag for one period, and at the end of that period it copies the live counts into bus-side registers. A read of the bus-side milliseconds also latches the bus-side seconds into a shadow register, so that a later read of the shadow returns a seconds value that belongs to the same instant as the milliseconds just read.

Two seconds alarms and one milliseconds alarm compare against the counters at the moment each counter advances. A match sets a sticky status bit. Software clears a status bit by writing one to it. A mask register selects which status bits drive the single active-high level interrupt. The register interface is a plain single-cycle request port with no back-pressure: a request is taken in the cycle it is presented, and read data appears on the following cycle. A write presented while the busy flag is up is dropped.

Top module: `rtc_shadow`

## Requirements
- R1: After reset every register reads 0, the busy bit reads 0 and `irq` is low.
- R2: Each reference strobe adds 1000 to an accumulator. When the sum reaches SLOW_HZ, SLOW_HZ is subtracted and the milliseconds advance by one. The step after 999 returns the milliseconds to 0 and adds one to the seconds.
- R3: Bit 0 of the busy register (offset 0x004) reads 1 for exactly one reference period in every eight. The busy pulses recur every eight reference periods.
- R4: The bus-side seconds (0x008) and milliseconds (0x010) change only at the copy at the end of a busy period, or on a seconds write. Between copies they hold still while the live counts advance.
- R5: A read of milliseconds (0x010) loads the bus-side seconds into the shadow register (0x00c).
- R6: A write presented while the busy bit is 1 changes no register.
- R7: A write to seconds (0x008) sets the live and bus-side seconds to the written value and clears the milliseconds and the accumulator.
- R8: The alarm registers are seconds alarm A (0x014), seconds alarm B (0x018) and the milliseconds alarm (0x01c, 10 bits). Status bit 0 (alarm A) or bit 1 (alarm B) sets when the seconds advance to a value equal to that alarm. Status bit 2 sets when the milliseconds advance to a value equal to the milliseconds alarm.
- R9: In the status register (0x02c), writing a 1 to a bit clears that bit and writing a 0 leaves it unchanged. Bits 3 and 4 (the countdown sources) always read 0.
- R10: `irq` is high exactly when some bit is set in both the status register and the mask register (0x028, bits 4:0, same layout as status).
- R11: Read data appears on `bus_rdata` in the cycle after the read request. It holds until the next read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe per reference period |
| bus_en | input | 1 | Register request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 1 | Level interrupt, active high |

## Verification
The hardest case to reach is a write that lands inside the busy period, which is only two bus cycles wide here. The stimulus watches the reference model's copy phase and presents the write exactly when the next edge falls inside the window. It then reads the register back to show that the value did not change. Alarm hits are reached by setting the seconds close to an alarm value and letting whole seconds elapse. A reference model running in step with the design compares the read data and the interrupt on every cycle.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  // Register byte offsets
  localparam int OFS_BUSY   = 'h04;
  localparam int OFS_SEC    = 'h08;
  localparam int OFS_SHADOW = 'h0c;
  localparam int OFS_MS     = 'h10;
  localparam int OFS_ALM0   = 'h14;  // seconds alarms follow at 4-byte stride
  localparam int OFS_MS_ALM = 'h1c;
  localparam int OFS_MASK   = 'h28;
  localparam int OFS_STAT   = 'h2c;

  // Interrupt source layout, shared by mask and status
  localparam int NUM_SEC_ALM = 2;  // bits 0..NUM_SEC_ALM-1
  localparam int IDX_MS_ALM  = 2;
  localparam int IRQ_W       = 5;  // bits 3,4: countdown sources, never set
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int SLOW_HZ     = 32768,
  parameter int MS_PER_SEC  = 1000,
  parameter int COPY_PERIOD = 8,
  parameter int DATA_W      = 32,
  parameter int MS_W        = $clog2(MS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              set_en,
  input  logic [DATA_W-1:0] set_val,
  output logic [DATA_W-1:0] sec_q,
  output logic [MS_W-1:0]   ms_q,
  output logic              busy,
  output logic              copy_now,
  output logic              ms_step,
  output logic [MS_W-1:0]   ms_next,
  output logic              sec_step,
  output logic [DATA_W-1:0] sec_next
);
  localparam int ACC_W = $clog2(SLOW_HZ + MS_PER_SEC + 1);
  localparam int PH_W  = (COPY_PERIOD > 1) ? $clog2(COPY_PERIOD) : 1;

  logic [ACC_W-1:0] acc_q, acc_sum;
  logic [PH_W-1:0]  phase_q;
  logic             ms_wrap;

  assign acc_sum  = acc_q + ACC_W'(MS_PER_SEC);
  assign ms_step  = tick && (acc_sum >= ACC_W'(SLOW_HZ));
  assign ms_wrap  = (ms_q == MS_W'(MS_PER_SEC - 1));
  assign ms_next  = ms_wrap ? '0 : ms_q + MS_W'(1);
  assign sec_step = ms_step && ms_wrap;
  assign sec_next = sec_q + DATA_W'(1);
  assign busy     = (phase_q == PH_W'(COPY_PERIOD - 1));
  assign copy_now = tick && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ms_q  <= '0;
      sec_q <= '0;
    end else if (set_en) begin
      acc_q <= '0;
      ms_q  <= '0;
      sec_q <= set_val;
    end else if (tick) begin
      acc_q <= ms_step ? acc_sum - ACC_W'(SLOW_HZ) : acc_sum;
      if (ms_step)  ms_q  <= ms_next;
      if (sec_step) sec_q <= sec_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= busy ? '0 : phase_q + PH_W'(1);
  end

  AST_MS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q < MS_W'(MS_PER_SEC)); // R2
  AST_COUNT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !set_en) |=> ($stable(ms_q) && $stable(sec_q))); // R2
  AST_BUSY_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick) |=> !busy); // R3
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_shadow_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MS_W   = 10,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] sec_q,
  input  logic [MS_W-1:0]   ms_q,
  input  logic              busy,
  input  logic              copy_now,
  input  logic              ms_step,
  input  logic [MS_W-1:0]   ms_next,
  input  logic              sec_step,
  input  logic [DATA_W-1:0] sec_next,
  output logic              set_en,
  output logic [DATA_W-1:0] set_val,
  output logic [IRQ_W-1:0]  status_q,
  output logic [IRQ_W-1:0]  mask_q
);
  logic                                wr_ok, rd_req, ms_hit;
  logic [DATA_W-1:0]                   bsec_q, shadow_q, rd_next;
  logic [MS_W-1:0]                     bms_q, alm_ms_q;
  logic [NUM_SEC_ALM-1:0][DATA_W-1:0]  alm_sec;
  logic [NUM_SEC_ALM-1:0]              sec_hit;
  logic [IRQ_W-1:0]                    hits, clr;

  assign wr_ok   = bus_en && bus_we && !busy;
  assign rd_req  = bus_en && !bus_we;
  assign set_en  = wr_ok && (bus_addr == ADDR_W'(OFS_SEC));
  assign set_val = bus_wdata;

  for (genvar g = 0; g < NUM_SEC_ALM; g++) begin : g_sec_alm
    logic [DATA_W-1:0] alm_q;
    logic              sel;
    assign sel = (bus_addr == ADDR_W'(OFS_ALM0 + 4 * g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           alm_q <= '0;
      else if (wr_ok && sel) alm_q <= bus_wdata;
    end
    assign alm_sec[g] = alm_q;
    assign sec_hit[g] = sec_step && (sec_next == alm_q);
  end

  assign ms_hit = ms_step && (ms_next == alm_ms_q);

  always_comb begin
    hits = '0;
    hits[NUM_SEC_ALM-1:0] = sec_hit;
    hits[IDX_MS_ALM]      = ms_hit;
    clr = (wr_ok && bus_addr == ADDR_W'(OFS_STAT)) ? bus_wdata[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsec_q   <= '0;
      bms_q    <= '0;
      shadow_q <= '0;
      alm_ms_q <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (set_en) begin
        bsec_q <= bus_wdata;
        bms_q  <= '0;
      end else if (copy_now) begin
        bsec_q <= sec_q;
        bms_q  <= ms_q;
      end
      if (rd_req && bus_addr == ADDR_W'(OFS_MS)) shadow_q <= bsec_q;
      if (wr_ok && bus_addr == ADDR_W'(OFS_MS_ALM)) alm_ms_q <= bus_wdata[MS_W-1:0];
      if (wr_ok && bus_addr == ADDR_W'(OFS_MASK))   mask_q   <= bus_wdata[IRQ_W-1:0];
      status_q <= (status_q & ~clr) | hits;
    end
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      ADDR_W'(OFS_BUSY):   rd_next = DATA_W'(busy);
      ADDR_W'(OFS_SEC):    rd_next = bsec_q;
      ADDR_W'(OFS_SHADOW): rd_next = shadow_q;
      ADDR_W'(OFS_MS):     rd_next = DATA_W'(bms_q);
      ADDR_W'(OFS_MS_ALM): rd_next = DATA_W'(alm_ms_q);
      ADDR_W'(OFS_MASK):   rd_next = DATA_W'(mask_q);
      ADDR_W'(OFS_STAT):   rd_next = DATA_W'(status_q);
      default: ;
    endcase
    for (int k = 0; k < NUM_SEC_ALM; k++)
      if (bus_addr == ADDR_W'(OFS_ALM0 + 4 * k)) rd_next = alm_sec[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_next;
  end

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_en && bus_we) |=> ($stable(mask_q) && $stable(alm_ms_q))); // R6
  AST_BUS_TIME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_now && !set_en) |=> ($stable(bsec_q) && $stable(bms_q))); // R4
  AST_SHADOW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_addr == ADDR_W'(OFS_MS)) |=> (shadow_q == $past(bsec_q))); // R5
  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_hit[0] |=> status_q[0]); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[0] && !sec_hit[0])
    |=> !status_q[0]); // R9
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_shadow_pkg::*;
#(
  parameter int SLOW_HZ     = 32768,
  parameter int MS_PER_SEC  = 1000,
  parameter int COPY_PERIOD = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int MS_W = $clog2(MS_PER_SEC);

  logic [DATA_W-1:0] sec_q, sec_next, set_val;
  logic [MS_W-1:0]   ms_q, ms_next;
  logic              busy, copy_now, ms_step, sec_step, set_en;
  logic [IRQ_W-1:0]  status_w, mask_w;

  rtc_timebase #(
    .SLOW_HZ(SLOW_HZ), .MS_PER_SEC(MS_PER_SEC), .COPY_PERIOD(COPY_PERIOD),
    .DATA_W(DATA_W), .MS_W(MS_W)
  ) u_timebase (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .set_en(set_en), .set_val(set_val),
    .sec_q(sec_q), .ms_q(ms_q), .busy(busy), .copy_now(copy_now),
    .ms_step(ms_step), .ms_next(ms_next), .sec_step(sec_step), .sec_next(sec_next)
  );

  rtc_regfile #(.DATA_W(DATA_W), .MS_W(MS_W), .ADDR_W(ADDR_W)) u_regfile (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_q(sec_q), .ms_q(ms_q),
    .busy(busy), .copy_now(copy_now), .ms_step(ms_step), .ms_next(ms_next),
    .sec_step(sec_step), .sec_next(sec_next), .set_en(set_en), .set_val(set_val),
    .status_q(status_w), .mask_q(mask_w)
  );

  assign irq = |(status_w & mask_w);

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_w != '0)); // R10
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_w != '0)); // R10
endmodule

// File: tb/rtc_shadow_bench.sv
module rtc_shadow_bench;
  localparam int HZ = 2048;
  localparam int TICK_DIV = 2;

  logic        clk = 1'b0, rst_n = 1'b0, tick_32k = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0, tick_en = 0;

  always #2 clk = ~clk;

  rtc_shadow #(.SLOW_HZ(HZ)) u_rtc_shadow (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model state
  logic [31:0] m_sec, m_bsec, m_shadow, m_a0, m_a1, m_rdata;
  int          m_ms, m_bms, m_acc, m_phase, m_am, m_mask, m_status;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_bsec = 0; m_shadow = 0; m_a0 = 0; m_a1 = 0; m_rdata = 0;
      m_ms = 0; m_bms = 0; m_acc = 0; m_phase = 0; m_am = 0; m_mask = 0; m_status = 0;
    end else begin
      automatic bit busy_o = (m_phase == 7);
      automatic bit wr_ok  = bus_en && bus_we && !busy_o;
      automatic logic [31:0] o_sec = m_sec, o_bsec = m_bsec;
      automatic int o_ms = m_ms, o_bms = m_bms, hits = 0, clr = 0;
      if (bus_en && !bus_we) begin
        case (bus_addr)
          8'h04: m_rdata = {31'd0, busy_o};
          8'h08: m_rdata = o_bsec;
          8'h0c: m_rdata = m_shadow;
          8'h10: m_rdata = o_bms;
          8'h14: m_rdata = m_a0;
          8'h18: m_rdata = m_a1;
          8'h1c: m_rdata = m_am;
          8'h28: m_rdata = m_mask;
          8'h2c: m_rdata = m_status;
          default: m_rdata = 0;
        endcase
        if (bus_addr == 8'h10) m_shadow = o_bsec;
      end
      if (tick_32k) begin
        m_acc = m_acc + 1000;
        if (m_acc >= HZ) begin
          m_acc = m_acc - HZ;
          m_ms = (o_ms == 999) ? 0 : o_ms + 1;
          if (m_ms == m_am) hits |= 4;
          if (o_ms == 999) begin
            m_sec = o_sec + 1;
            if (m_sec == m_a0) hits |= 1;
            if (m_sec == m_a1) hits |= 2;
          end
        end
        if (busy_o) begin m_bsec = o_sec; m_bms = o_ms; m_phase = 0; end
        else m_phase = m_phase + 1;
      end
      if (wr_ok) begin
        case (bus_addr)
          8'h08: begin m_sec = bus_wdata; m_ms = 0; m_acc = 0; m_bsec = bus_wdata; m_bms = 0; end
          8'h14: m_a0 = bus_wdata;
          8'h18: m_a1 = bus_wdata;
          8'h1c: m_am = int'(bus_wdata & 32'h3ff);
          8'h28: m_mask = int'(bus_wdata & 32'h1f);
          8'h2c: clr = int'(bus_wdata & 32'h1f);
          default: ;
        endcase
      end
      m_status = (m_status & ~clr) | hits;
    end
  end

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check32("R11 read data vs model", bus_rdata, m_rdata);
      check32("R10 irq vs model", {31'd0, irq}, {31'd0, (m_status & m_mask) != 0});
    end
  end

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      tick_32k = tick_en && (cnt % TICK_DIV == 0);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    while (m_phase == 7) @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic wr_in_busy(input logic [7:0] a, input logic [31:0] d);
    while (m_phase != 7) @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    bus_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, exp_shadow;
    int last_rise, high_run;
    bit prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check32("R1 irq after reset", {31'd0, irq}, 0);
    foreach (v2[i]) ;
    for (int a = 4; a <= 'h2c; a += 4) begin
      rd(a[7:0], v);
      check32($sformatf("R1 reg %0h after reset", a), v, 0);
    end

    tick_en = 1;
    // R3: busy period and width, read continuously
    bus_en = 1; bus_we = 0; bus_addr = 8'h04;
    last_rise = -1; high_run = 0; prev = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (bus_rdata[0] && !prev) begin
        if (last_rise >= 0) check32("R3 busy period", c - last_rise, 8 * TICK_DIV);
        last_rise = c; high_run = 0;
      end
      if (bus_rdata[0]) high_run++;
      if (!bus_rdata[0] && prev) check32("R3 busy width", high_run, TICK_DIV);
      prev = bus_rdata[0];
    end
    bus_en = 0;

    // R7: set time
    wr(8'h08, 32'd100);
    rd(8'h08, v);
    check32("R7 seconds after set", v, 100);
    // R5: ms read latches shadow
    exp_shadow = m_bsec;
    rd(8'h10, v);
    rd(8'h0c, v2);
    check32("R5 shadow after ms read", v2, exp_shadow);
    check32("R5 shadow equals set time", v2, 100);

    // R4: bus ms holds between copies
    while (m_phase != 0) @(negedge clk);
    rd(8'h10, v);
    repeat (8) @(negedge clk);
    rd(8'h10, v2);
    check32("R4 bus ms held between copies", v2, v);

    // R2: one second later the seconds carried
    repeat (HZ * TICK_DIV + 60) @(negedge clk);
    rd(8'h08, v);
    check32("R2 seconds carry", v, 101);
    check32("R2 ms in range", {31'd0, m_ms < 1000}, 1);

    // R8 / R10: alarm A masked in, alarm B not
    wr(8'h2c, 32'h1f);
    wr(8'h14, 32'd102);
    wr(8'h18, 32'd103);
    wr(8'h28, 32'h01);
    check32("R10 irq low before alarm", {31'd0, irq}, 0);
    repeat (HZ * TICK_DIV + 60) @(negedge clk);
    check32("R10 irq on alarm A", {31'd0, irq}, 1);
    rd(8'h2c, v);
    check32("R8 alarm A status", v & 32'h1, 1);
    // R9: write 0 has no effect, write 1 clears
    wr(8'h2c, 32'h0);
    rd(8'h2c, v);
    check32("R9 zero write keeps bit", v & 32'h1, 1);
    wr(8'h2c, 32'h1);
    rd(8'h2c, v);
    check32("R9 one write clears bit", v & 32'h1, 0);
    check32("R10 irq drops after clear", {31'd0, irq}, 0);
    repeat (HZ * TICK_DIV) @(negedge clk);
    rd(8'h2c, v);
    check32("R8 alarm B status", v & 32'h2, 2);
    check32("R10 unmasked alarm B keeps irq low", {31'd0, irq}, 0);

    // R8: milliseconds alarm
    wr(8'h1c, 32'd500);
    wr(8'h2c, 32'h1f);
    rd(8'h1c, v);
    check32("R8 ms alarm readback", v, 500);
    repeat (HZ * TICK_DIV + 60) @(negedge clk);
    rd(8'h2c, v);
    check32("R8 ms alarm status", v & 32'h4, 4);
    wr(8'h28, 32'h04);
    check32("R10 irq on ms alarm", {31'd0, irq}, 1);

    // R9: countdown bits never set
    wr(8'h28, 32'h1f);
    rd(8'h2c, v);
    check32("R9 countdown bits zero", v & 32'h18, 0);

    // R6: writes in the busy window are dropped
    wr_in_busy(8'h28, 32'h0);
    rd(8'h28, v);
    check32("R6 mask unchanged", v, 32'h1f);
    rd(8'h08, v2);
    wr_in_busy(8'h08, 32'd7);
    rd(8'h08, v);
    check32("R6 seconds not set", {31'd0, v != 7}, 1);

    // R11: unmapped offsets
    rd(8'h20, v);
    check32("R11 unmapped 0x20", v, 0);
    rd(8'h3c, v);
    check32("R11 unmapped 0x3c", v, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule